// File: doc/BRIEF.md
# Paging codeword error corrector

This block takes in one received 32-bit paging codeword at a time and returns the codeword with its errors repaired. Each result carries a code that says which kind of repair was made. The word holds 21 data bits, 10 check bits of a BCH(31,21) code and one overall even-parity bit. Correction of up to two random bit errors is always on. The `burst_en` input adds a second mode, which repairs three wrong bits that all lie within a 4-bit window. Random correction is tried first, and burst correction is only tried when random correction fails. A later stage uses the result code to drop calls that contain too many errors.

Codewords flow in and out over valid/ready. An input word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the block holds every output and takes no new word. For address codewords the block also brings out the two-bit function field and two call-format flags, decoded from the corrected word.

Bit layout: `cw[31]` is the first bit sent and is the flag bit (0 means address). `cw[31:11]` are the 21 data bits. `cw[10:1]` is the remainder of `cw[31:11]`·x^10 divided by g(x) = x^10+x^9+x^8+x^6+x^5+x^3+1. `cw[0]` makes the count of ones in the whole word even.

Top module: `pcw_corrector`

## Requirements
- R1: A valid codeword (zero syndrome, even parity) comes out unchanged with result code 0. `out_valid` rises exactly two rising edges after the word is accepted, provided `out_ready` stays high, and is low after the first of those edges.
- R2: A single wrong bit at any of the 32 positions, including the parity bit `cw[0]`, is corrected, and the result code is 1.
- R3: Any two wrong bits among the 32 positions are corrected, and the result code is 2.
- R4: With `burst_en`=1, three wrong bits that all lie within 4 adjacent positions of the 32-bit word are corrected, and the result code is 3.
- R5: With `burst_en`=0, such a 3-bit burst gives result code 4, and `out_cw` equals the received word bit for bit.
- R6: With `burst_en`=0, three scattered wrong bits give result code 4, and the word passes through unmodified.
- R7: For an address word (`cw[31]`=0), `out_func` equals the corrected `cw[12:11]`. Its encoding is 00 numeric, 01 alert-only 1, 10 alert-only 2, 11 alphanumeric. `out_digit4` is high for 00 and `out_char7` is high for 11. For a message word (`cw[31]`=1), `out_func`, `out_digit4` and `out_char7` are 0, and `out_is_addr` is 0.
- R8: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values. A word offered during the stall is accepted on the edge where the stall ends, and its result follows one edge later.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_en | input | 1 | Enables 3-in-4 burst correction; sampled with each accepted word |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word |
| in_cw | input | 32 | Received codeword |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_cw | output | 32 | Corrected codeword |
| out_etype | output | 3 | 0 clean, 1 one bit, 2 two bits, 3 burst, 4 uncorrectable |
| out_is_addr | output | 1 | Word is an address codeword |
| out_func | output | 2 | Function field of an address word |
| out_digit4 | output | 1 | Numeric call, 4-bit digits |
| out_char7 | output | 1 | Alphanumeric call, 7-bit characters |

## Verification
Every result is due at the second rising edge after its word is accepted. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. It checks that `out_valid` is still low after the first edge and that the full result is present after the second. The stall scenario holds `out_ready` low for several cycles. It checks that the first result and `in_ready`=0 stay put throughout, and that the queued word appears on the falling edge right after `out_ready` returns.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int CW_W     = 32;
  localparam int DATA_W   = 21;
  localparam int CHK_W    = 10;
  localparam int BCH_N    = CW_W - 1;
  localparam int FUNC_LSB = CW_W - DATA_W;
  localparam logic [CHK_W-1:0] GEN_LOW = 10'h369;

  typedef enum logic [2:0] {
    ET_CLEAN = 3'd0,
    ET_ONE   = 3'd1,
    ET_TWO   = 3'd2,
    ET_BURST = 3'd3,
    ET_FAIL  = 3'd4
  } etype_t;

  function automatic logic [CHK_W-1:0] bch_rem(input logic [BCH_N-1:0] v);
    logic [CHK_W-1:0] r;
    logic fb;
    r = '0;
    for (int k = BCH_N - 1; k >= 0; k--) begin
      fb = r[CHK_W-1] ^ v[k];
      r  = {r[CHK_W-2:0], 1'b0};
      if (fb) r = r ^ GEN_LOW;
    end
    return r;
  endfunction

  function automatic logic [BCH_N*CHK_W-1:0] syn_table();
    logic [BCH_N*CHK_W-1:0] t;
    t = '0;
    for (int i = 0; i < BCH_N; i++)
      t[i*CHK_W +: CHK_W] = bch_rem(BCH_N'(1) << i);
    return t;
  endfunction
endpackage

// File: rtl/pcw_syndrome.sv
module pcw_syndrome
  import pcw_pkg::*;
(
  input  logic [CW_W-1:0]  cw,
  output logic [CHK_W-1:0] syn,
  output logic             par
);
  assign syn = bch_rem(cw[CW_W-1:1]);
  assign par = ^cw;
endmodule

// File: rtl/pcw_locator.sv
module pcw_locator
  import pcw_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic [CHK_W-1:0] syn,
  input  logic             par,
  input  logic             burst_en,
  output logic [CW_W-1:0]  flip,
  output etype_t           etype
);
  localparam logic [BCH_N*CHK_W-1:0] SYN_TAB = syn_table();

  // syndrome contributed by an error at codeword bit pos (bit 0 is parity only)
  function automatic logic [CHK_W-1:0] syn_at(input int pos);
    if (pos == 0) return '0;
    return SYN_TAB[(pos-1)*CHK_W +: CHK_W];
  endfunction

  logic [CW_W-1:0] m_one, m_two, m_burst;
  logic            hit_one, hit_two, hit_burst;

  // singles and pairs are unique by code distance, so hits are simply ORed
  always_comb begin
    m_one = '0;
    m_two = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (syn == syn_at(i)) m_one[i] = 1'b1;
      for (int j = i + 1; j < CW_W; j++)
        if (syn == (syn_at(i) ^ syn_at(j))) begin
          m_two[i] = 1'b1;
          m_two[j] = 1'b1;
        end
    end
    hit_one = |m_one;
    hit_two = |m_two;
  end

  // three-bit bursts: first match in ascending start position wins
  always_comb begin
    m_burst   = '0;
    hit_burst = 1'b0;
    for (int b = 0; b < CW_W - 2; b++)
      for (int e = b + 2; e < b + BURST_LEN; e++)
        for (int m = b + 1; m < e; m++)
          if (e < CW_W && !hit_burst &&
              syn == (syn_at(b) ^ syn_at(m) ^ syn_at(e))) begin
            hit_burst  = 1'b1;
            m_burst[b] = 1'b1;
            m_burst[m] = 1'b1;
            m_burst[e] = 1'b1;
          end
  end

  always_comb begin
    flip  = '0;
    etype = ET_FAIL;
    if (syn == '0) begin
      flip[0] = par;
      etype   = par ? ET_ONE : ET_CLEAN;
    end else if (hit_one) begin
      flip    = m_one;
      flip[0] = ~par;
      etype   = par ? ET_ONE : ET_TWO;
    end else if (hit_two && !par) begin
      flip  = m_two;
      etype = ET_TWO;
    end else if (hit_burst && par && burst_en) begin
      flip  = m_burst;
      etype = ET_BURST;
    end
  end
endmodule

// File: rtl/pcw_func_decode.sv
module pcw_func_decode
  import pcw_pkg::*;
(
  input  logic [CW_W-1:0] cw,
  output logic            is_addr,
  output logic [1:0]      func,
  output logic            digit4,
  output logic            char7
);
  assign is_addr = ~cw[CW_W-1];
  assign func    = is_addr ? cw[FUNC_LSB+1:FUNC_LSB] : 2'b00;
  assign digit4  = is_addr && (func == 2'b00);
  assign char7   = is_addr && (func == 2'b11);
endmodule

// File: rtl/pcw_corrector.sv
module pcw_corrector
  import pcw_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            burst_en,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CW_W-1:0] in_cw,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CW_W-1:0] out_cw,
  output logic [2:0]      out_etype,
  output logic            out_is_addr,
  output logic [1:0]      out_func,
  output logic            out_digit4,
  output logic            out_char7
);
  logic             adv;
  logic [CHK_W-1:0] syn0;
  logic             par0;

  logic             s1_valid, s1_par, s1_burst;
  logic [CW_W-1:0]  s1_cw;
  logic [CHK_W-1:0] s1_syn;

  logic [CW_W-1:0]  loc_flip, fixed;
  etype_t           loc_type;
  logic             fd_addr, fd_d4, fd_c7;
  logic [1:0]       fd_func;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  pcw_syndrome u_syn (.cw(in_cw), .syn(syn0), .par(par0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_cw    <= '0;
      s1_syn   <= '0;
      s1_par   <= 1'b0;
      s1_burst <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_cw    <= in_cw;
        s1_syn   <= syn0;
        s1_par   <= par0;
        s1_burst <= burst_en;
      end
    end
  end

  pcw_locator #(.BURST_LEN(BURST_LEN)) u_loc (
    .syn(s1_syn), .par(s1_par), .burst_en(s1_burst),
    .flip(loc_flip), .etype(loc_type)
  );

  assign fixed = s1_cw ^ loc_flip;

  pcw_func_decode u_fd (
    .cw(fixed), .is_addr(fd_addr), .func(fd_func),
    .digit4(fd_d4), .char7(fd_c7)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_cw      <= '0;
      out_etype   <= 3'd0;
      out_is_addr <= 1'b0;
      out_func    <= 2'b00;
      out_digit4  <= 1'b0;
      out_char7   <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_cw      <= fixed;
        out_etype   <= loc_type;
        out_is_addr <= fd_addr;
        out_func    <= fd_func;
        out_digit4  <= fd_d4;
        out_char7   <= fd_c7;
      end
    end
  end

  AST_ACCEPT_TO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_valid); // R8
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cw) && $stable(out_etype))); // R8
  AST_BURST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_burst) |-> (loc_type != ET_BURST)); // R5
  AST_FAIL_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && loc_type == ET_FAIL) |-> (loc_flip == '0)); // R6
  AST_FLIP_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && loc_type != ET_FAIL) |-> ($countones(loc_flip) == int'(loc_type))); // R2
endmodule

// File: tb/pcw_corrector_tb.sv
module pcw_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_cw = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_cw;
  logic [2:0]  out_etype;
  logic        out_is_addr, out_digit4, out_char7;
  logic [1:0]  out_func;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pcw_corrector dut_i (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_cw(in_cw),
    .out_valid(out_valid), .out_ready(out_ready), .out_cw(out_cw),
    .out_etype(out_etype), .out_is_addr(out_is_addr), .out_func(out_func),
    .out_digit4(out_digit4), .out_char7(out_char7)
  );

  function automatic logic [31:0] encode(input logic [20:0] d);
    logic [9:0] r = '0;
    logic [31:0] w;
    logic fb;
    for (int k = 20; k >= 0; k--) begin
      fb = r[9] ^ d[k];
      r  = {r[8:0], 1'b0};
      if (fb) r = r ^ 10'h369;
    end
    w = {d, r, 1'b0};
    w[0] = ^w[31:1];
    return w;
  endfunction

  function automatic logic [31:0] bits3(input int a, input int b, input int c);
    return (32'd1 << a) | (32'd1 << b) | (32'd1 << c);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_word(input logic [31:0] w, input logic be,
                          input logic [31:0] ecw, input logic [2:0] et, input string tag);
    @(negedge clk);
    in_cw = w; burst_en = be; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " not yet valid (R1)"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " cw"}, out_cw, ecw);
    chk({tag, " etype"}, {29'd0, out_etype}, {29'd0, et});
  endtask

  task automatic t_reset();
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_clean();
    logic [31:0] w;
    for (int n = 0; n < 3; n++) begin
      w = encode(21'($urandom));
      run_word(w, n[0], w, 3'd0, "R1 clean");
    end
  endtask

  task automatic t_single();
    logic [31:0] w;
    for (int p = 0; p < 32; p++) begin
      w = encode(21'($urandom));
      run_word(w ^ (32'd1 << p), 1'b0, w, 3'd1, "R2 single");
    end
  endtask

  task automatic t_double();
    int pa[6] = '{0, 0, 5, 30, 11, 1};
    int pb[6] = '{1, 31, 17, 31, 12, 20};
    logic [31:0] w;
    for (int n = 0; n < 6; n++) begin
      w = encode(21'($urandom));
      run_word(w ^ (32'd1 << pa[n]) ^ (32'd1 << pb[n]), 1'b1, w, 3'd2, "R3 double");
    end
  endtask

  task automatic t_burst(input logic be);
    logic [31:0] pats[4];
    logic [31:0] w;
    pats[0] = bits3(0, 1, 2);
    pats[1] = bits3(29, 30, 31);
    pats[2] = bits3(17, 18, 20);
    pats[3] = bits3(3, 5, 6);
    for (int n = 0; n < 4; n++) begin
      w = encode(21'($urandom));
      if (be) run_word(w ^ pats[n], 1'b1, w, 3'd3, "R4 burst on");
      else    run_word(w ^ pats[n], 1'b0, w ^ pats[n], 3'd4, "R5 burst off");
    end
  endtask

  task automatic t_scatter();
    logic [31:0] w, e;
    w = encode(21'h0a5c3);
    e = w ^ bits3(2, 15, 31);
    run_word(e, 1'b0, e, 3'd4, "R6 scatter a");
    w = encode(21'h1f00e);
    e = w ^ bits3(1, 9, 25);
    run_word(e, 1'b0, e, 3'd4, "R6 scatter b");
  endtask

  task automatic t_func();
    logic [31:0] w;
    for (int f = 0; f < 4; f++) begin
      w = encode({1'b0, 18'($urandom), 2'(f)});
      run_word(w ^ (32'd1 << 11), 1'b0, w, 3'd1, "R7 addr");
      chk("R7 is_addr", {31'd0, out_is_addr}, 32'd1);
      chk("R7 func", {30'd0, out_func}, f);
      chk("R7 digit4", {31'd0, out_digit4}, {31'd0, f == 0});
      chk("R7 char7", {31'd0, out_char7}, {31'd0, f == 3});
    end
    w = encode({1'b1, 18'h2b3c1, 2'b11});
    run_word(w, 1'b0, w, 3'd0, "R7 msg");
    chk("R7 msg flags", {28'd0, out_is_addr, out_func, out_digit4 | out_char7}, 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] a, b;
    a = encode(21'h12345);
    b = encode(21'h0beef);
    @(negedge clk);
    out_ready = 1'b0; in_cw = a; burst_en = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_cw = b ^ 32'h0000_0100;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 first valid", {31'd0, out_valid}, 32'd1);
    chk("R8 first cw", out_cw, a);
    chk("R8 ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    chk("R8 held cw", out_cw, a);
    chk("R8 held etype", {29'd0, out_etype}, 32'd0);
    chk("R8 still not ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 second valid", {31'd0, out_valid}, 32'd1);
    chk("R8 second cw", out_cw, b);
    chk("R8 second etype", {29'd0, out_etype}, 32'd1);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_burst(1'b1);
    t_burst(1'b0);
    t_scatter();
    t_func();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule